// File: doc/BRIEF.md
# Event-Count Interrupt Prescaler With Status Flag

This block sits beside a PWM timer. It counts single-cycle timing-event strobes and raises a one-cycle interrupt pulse once a programmable number of them (one, two or three) has been seen. A sticky status flag gates the interrupt path, and one further interrupt can wait in a single pending slot until software clears the flag. Software can also force an interrupt through the same gating.

The block also latches a status flag for each of two ADC start-of-conversion pulse streams. Those pulses pass through to the outputs one cycle later, whatever state their flags are in.

Software reaches the block through a small register bus. A write lands on the clock edge. Read data is combinational from the address. Writes to the period field that land in the same cycle as an event, or that move the period to or below the running count, have defined results.

Top module: `epi_prescaler`

## Requirements
- R1: With period field CFG[1:0] = 00, events are not counted, no interrupt is issued, and a force (ACT bit 1) is ignored.
- R2: With period P in {1,2,3} and enable CFG[4] = 1, the interrupt is issued in the cycle after the P-th counted event, counting from zero. The count reads at CFG[9:8].
- R3: With CFG[4] = 0, no interrupt is issued, and the count stops at the period value. Setting the enable later while the count equals the period issues the interrupt.
- R4: The interrupt output `irq_o` is a one-cycle pulse. The status flag (FLG bit 0) reads 1 in the same cycle as the pulse, and the count reads 0 in that cycle.
- R5: No interrupt is issued in the cycle after the flag reads 1. A count match while the flag is set is held as one pending interrupt. After a clear (ACT bit 0), the flag reads 0 for one cycle and the pending pulse then appears in the next cycle.
- R6: Writing a period equal to the current count issues the interrupt, provided the enable is set and the flag is clear.
- R7: An event in the same cycle as a period write is counted and compared against the newly written period.
- R8: Writing a non-zero period below the current count sets the count to 0 and issues no interrupt.
- R9: A force (ACT bit 1) with a non-zero period acts as a count match. It is gated by the enable, the flag and the pending slot, and it returns the count to 0.
- R10: Each start-of-conversion input pulse appears on `soc_o` one cycle later and sets its flag (FLG bit 4+i) in that same cycle. Pulses continue while the flag is set. ACT bit 4+i clears flag i, and a set in the same cycle wins over the clear.
- R11: After reset every register, count and flag reads 0. The action register (address 2), address 3 and unused bits read 0. Addresses: 0 = CFG, 1 = FLG, 2 = ACT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| evt_i | input | 1 | Selected timing-event strobe |
| soc_i | input | N_SOC | Start-of-conversion pulses |
| irq_o | output | 1 | Interrupt pulse |
| soc_o | output | N_SOC | Start-of-conversion pulses, delayed one cycle |

## Verification
A count that drifts from the number of events seen puts the interrupt pulse a cycle early or late. It also shows at once in CFG[9:8] on the next read. A flag or pending bit that is stuck or lost shows within two cycles of a clear: either a pulse that should follow the clear is missing, or a pulse appears while FLG bit 0 already read 1. Random traffic is checked against a cycle-level reference model on every cycle. Directed sequences pin down the period-write races and the pending-release timing, where an off-by-one cycle error would otherwise hide.

// File: rtl/epi_pkg.sv
package epi_pkg;
  // register addresses
  localparam int ADDR_CFG = 0;
  localparam int ADDR_FLG = 1;
  localparam int ADDR_ACT = 2;
  // CFG field positions
  localparam int CFG_PER_LSB = 0;
  localparam int CFG_EN_BIT  = 4;
  localparam int CFG_CNT_LSB = 8;
  // FLG field positions
  localparam int FLG_IRQ_BIT = 0;
  localparam int FLG_SOC_LSB = 4;
  // ACT field positions
  localparam int ACT_CLR_BIT  = 0;
  localparam int ACT_FRC_BIT  = 1;
  localparam int ACT_SCLR_LSB = 4;
endpackage

// File: rtl/epi_rst_sync.sv
module epi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/epi_cfg_regs.sv
module epi_cfg_regs
  import epi_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int N_SOC  = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [CNT_W-1:0]  per_q,
  output logic              en_q,
  output logic [CNT_W-1:0]  per_eff,
  output logic              en_eff,
  output logic              cfg_wr,
  output logic              irq_clr,
  output logic              irq_frc,
  output logic [N_SOC-1:0]  soc_clr
);
  logic              act_wr;
  logic [CNT_W-1:0]  per_d;
  logic              en_d;
  logic              unused_wdata;

  assign cfg_wr  = bus_wr && (bus_addr == ADDR_W'(ADDR_CFG));
  assign act_wr  = bus_wr && (bus_addr == ADDR_W'(ADDR_ACT));
  assign irq_clr = act_wr && bus_wdata[ACT_CLR_BIT];
  assign irq_frc = act_wr && bus_wdata[ACT_FRC_BIT];
  assign soc_clr = act_wr ? bus_wdata[ACT_SCLR_LSB +: N_SOC] : '0;

  // value in effect this cycle: a write takes effect for this cycle's decisions
  assign per_eff = cfg_wr ? bus_wdata[CFG_PER_LSB +: CNT_W] : per_q;
  assign en_eff  = cfg_wr ? bus_wdata[CFG_EN_BIT] : en_q;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    per_d = per_q;
    en_d  = en_q;
    if (cfg_wr) begin
      per_d = per_eff;
      en_d  = en_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      en_q  <= 1'b0;
    end else if (cfg_wr) begin
      per_q <= per_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/epi_evt_count.sv
module epi_evt_count #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             cfg_wr,
  input  logic             force_i,
  input  logic [CNT_W-1:0] per_q,
  input  logic [CNT_W-1:0] per_eff,
  input  logic             take_i,
  output logic             per_on,
  output logic             req_o,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             inc;
  logic             reached;
  logic [CNT_W-1:0] cnt_e;
  logic [CNT_W-1:0] cnt_d;

  assign per_on = (per_eff != '0);
  // an event in a write cycle counts even if the old period was zero
  assign inc    = evt_i && ((per_q != '0) || cfg_wr);

  always_comb begin
    cnt_e   = cnt_q;
    reached = 1'b0;
    if (!per_on) begin
      if (inc && (cnt_q != CNT_MAX)) cnt_e = cnt_q + 1'b1;
    end else if (cnt_q > per_eff) begin
      cnt_e = '0;
    end else begin
      if (inc && (cnt_q < per_eff)) cnt_e = cnt_q + 1'b1;
      reached = (cnt_e == per_eff);
    end
  end

  assign req_o = per_on && (reached || force_i);
  assign cnt_d = take_i ? '0 : cnt_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/epi_irq_gate.sv
module epi_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic en_i,
  input  logic per_on_i,
  input  logic clr_i,
  output logic take_o,
  output logic irq_o,
  output logic flag_q,
  output logic pend_q
);
  logic fire_new, fire_pend, to_pend, fire;
  logic flag_d, pend_d;

  always_comb begin
    fire_pend = en_i && per_on_i && pend_q && !flag_q;
    fire_new  = en_i && req_i && !flag_q && !pend_q;
    to_pend   = en_i && req_i && !fire_new && (!pend_q || fire_pend);
    take_o    = fire_new || to_pend;
    fire      = fire_new || fire_pend;

    pend_d = pend_q;
    if (to_pend)        pend_d = 1'b1;
    else if (fire_pend) pend_d = 1'b0;

    flag_d = flag_q;
    if (fire)       flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
      irq_o  <= fire;
    end
  end
endmodule

// File: rtl/epi_soc_flags.sv
module epi_soc_flags #(
  parameter int N_SOC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SOC-1:0] soc_i,
  input  logic [N_SOC-1:0] clr_i,
  output logic [N_SOC-1:0] soc_o,
  output logic [N_SOC-1:0] flag_q
);
  for (genvar g = 0; g < N_SOC; g++) begin : g_ch
    logic flag_d;
    always_comb begin
      flag_d = flag_q[g];
      if (soc_i[g])      flag_d = 1'b1;
      else if (clr_i[g]) flag_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
        soc_o[g]  <= 1'b0;
      end else begin
        flag_q[g] <= flag_d;
        soc_o[g]  <= soc_i[g];
      end
    end
  end
endmodule

// File: rtl/epi_prescaler.sv
module epi_prescaler
  import epi_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int N_SOC  = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_i,
  input  logic [N_SOC-1:0]  soc_i,
  output logic              irq_o,
  output logic [N_SOC-1:0]  soc_o
);
  logic             rst_n_s;
  logic [CNT_W-1:0] per_q, per_eff, cnt_q;
  logic             en_q, en_eff, cfg_wr, irq_clr, irq_frc;
  logic [N_SOC-1:0] soc_clr, soc_flag;
  logic             per_on, req, take, flag_q, pend_q;

  epi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n_s)
  );

  epi_cfg_regs #(.CNT_W(CNT_W), .N_SOC(N_SOC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .per_q(per_q), .en_q(en_q), .per_eff(per_eff),
    .en_eff(en_eff), .cfg_wr(cfg_wr), .irq_clr(irq_clr), .irq_frc(irq_frc),
    .soc_clr(soc_clr)
  );

  epi_evt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt_i), .cfg_wr(cfg_wr),
    .force_i(irq_frc), .per_q(per_q), .per_eff(per_eff), .take_i(take),
    .per_on(per_on), .req_o(req), .cnt_q(cnt_q)
  );

  epi_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n_s), .req_i(req), .en_i(en_eff),
    .per_on_i(per_on), .clr_i(irq_clr), .take_o(take), .irq_o(irq_o),
    .flag_q(flag_q), .pend_q(pend_q)
  );

  epi_soc_flags #(.N_SOC(N_SOC)) u_soc (
    .clk(clk), .rst_n(rst_n_s), .soc_i(soc_i), .clr_i(soc_clr),
    .soc_o(soc_o), .flag_q(soc_flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_CFG)) begin
      bus_rdata[CFG_PER_LSB +: CNT_W] = per_q;
      bus_rdata[CFG_EN_BIT]           = en_q;
      bus_rdata[CFG_CNT_LSB +: CNT_W] = cnt_q;
    end else if (bus_addr == ADDR_W'(ADDR_FLG)) begin
      bus_rdata[FLG_IRQ_BIT]          = flag_q;
      bus_rdata[FLG_SOC_LSB +: N_SOC] = soc_flag;
    end
  end
endmodule

// File: rtl/epi_chk.sv
module epi_chk #(
  parameter int CNT_W = 2,
  parameter int N_SOC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             flag_q,
  input logic             en_eff,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] per_q,
  input logic [N_SOC-1:0] soc_o,
  input logic [N_SOC-1:0] soc_flag
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r4_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_q);

  a_r5_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(flag_q));

  a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_eff));

  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0 && !cfg_wr) |=> !irq_o);

  for (genvar g = 0; g < N_SOC; g++) begin : g_soc
    a_r10_flag_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      soc_o[g] |-> soc_flag[g]);
  end
endmodule

bind epi_prescaler epi_chk #(.CNT_W(CNT_W), .N_SOC(N_SOC)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .irq_o(irq_o), .flag_q(flag_q),
  .en_eff(en_eff), .cfg_wr(cfg_wr), .per_q(per_q), .soc_o(soc_o),
  .soc_flag(soc_flag)
);

// File: tb/sim_epi_prescaler.sv
`timescale 1ns/1ps
module sim_epi_prescaler;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        evt_i;
  logic [1:0]  soc_i;
  logic        irq_o;
  logic [1:0]  soc_o;

  int tests = 0;
  int fails = 0;

  // reference model state
  logic [1:0] m_per, m_cnt, m_sf, m_soc;
  logic       m_en, m_flag, m_pend, m_irq;

  always #5 clk = ~clk;

  epi_prescaler u0 (
    .clk(clk), .arst_n(arst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .soc_i(soc_i), .irq_o(irq_o), .soc_o(soc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_per = 0; m_cnt = 0; m_sf = 0; m_soc = 0;
    m_en = 0; m_flag = 0; m_pend = 0; m_irq = 0;
  endtask

  // next state from the requirements, one clock edge
  task automatic model_step(input logic e, input logic w, input logic [1:0] a,
                            input logic [15:0] d, input logic [1:0] s);
    logic       cw, clr, frc, inc, on, reached, req, fp, fn, tp;
    logic [1:0] pe, ce, sclr;
    logic       ee;
    cw   = w && a == 2'd0;
    clr  = w && a == 2'd2 && d[0];
    frc  = w && a == 2'd2 && d[1];
    sclr = (w && a == 2'd2) ? d[5:4] : 2'b00;
    pe   = cw ? d[1:0] : m_per;
    ee   = cw ? d[4] : m_en;
    on   = pe != 0;
    inc  = e && (m_per != 0 || cw);
    reached = 0;
    ce = m_cnt;
    if (!on) begin
      if (inc && m_cnt != 3) ce = m_cnt + 1;
    end else if (m_cnt > pe) ce = 0;
    else begin
      if (inc && m_cnt < pe) ce = m_cnt + 1;
      reached = (ce == pe);
    end
    req = on && (reached || frc);
    fp  = ee && on && m_pend && !m_flag;
    fn  = ee && req && !m_flag && !m_pend;
    tp  = ee && req && !fn && (!m_pend || fp);
    m_cnt  = (fn || tp) ? 2'd0 : ce;
    m_pend = tp ? 1'b1 : (fp ? 1'b0 : m_pend);
    m_irq  = fn || fp;
    m_flag = m_irq ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_per  = pe;
    m_en   = ee;
    for (int i = 0; i < 2; i++) m_sf[i] = s[i] ? 1'b1 : (sclr[i] ? 1'b0 : m_sf[i]);
    m_soc = s;
  endtask

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    logic [15:0] r = 16'h0;
    if (a == 2'd0) begin r[1:0] = m_per; r[4] = m_en; r[9:8] = m_cnt; end
    else if (a == 2'd1) begin r[0] = m_flag; r[5:4] = m_sf; end
    return r;
  endfunction

  // one clock cycle of stimulus; returns at the following falling edge
  task automatic drive(input logic e, input logic w, input logic [1:0] a,
                       input logic [15:0] d, input logic [1:0] s);
    evt_i = e; bus_wr = w; bus_addr = a; bus_wdata = d; soc_i = s;
    model_step(e, w, a, d, s);
    @(posedge clk);
    #1;
    evt_i = 0; bus_wr = 0; soc_i = 0;
    @(negedge clk);
  endtask

  task automatic idle(); drive(0, 0, 2'd0, 16'h0, 2'b00); endtask
  task automatic ev();   drive(1, 0, 2'd0, 16'h0, 2'b00); endtask
  task automatic wr(input logic [1:0] a, input logic [15:0] d); drive(0, 1, a, d, 2'b00); endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic do_reset();
    arst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; evt_i = 0; soc_i = 0;
    model_reset();
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    do_reset();

    // R11 reset values
    rd(2'd0, v); chk("R11 cfg after reset", v, 16'h0);
    rd(2'd1, v); chk("R11 flags after reset", v, 16'h0);
    chk("R11 irq after reset", irq_o, 0);

    // R1 period 00
    wr(2'd0, 16'h0010); ev(); ev();
    rd(2'd0, v); chk("R1 no counting", v[9:8], 0);
    wr(2'd2, 16'h0002);
    chk("R1 force ignored", irq_o, 0);
    rd(2'd1, v); chk("R1 flag stays clear", v[0], 0);

    // R2 / R4 period 2
    wr(2'd0, 16'h0012); ev();
    chk("R2 no irq after first event", irq_o, 0);
    rd(2'd0, v); chk("R2 count one", v[9:8], 1);
    ev();
    chk("R2 irq on second event", irq_o, 1);
    rd(2'd1, v); chk("R4 flag with pulse", v[0], 1);
    rd(2'd0, v); chk("R4 count back to zero", v[9:8], 0);
    idle(); chk("R4 single cycle pulse", irq_o, 0);

    // R5 pending slot
    ev(); ev(); chk("R5 blocked by flag", irq_o, 0);
    wr(2'd2, 16'h0001);
    chk("R5 no pulse in clear cycle", irq_o, 0);
    rd(2'd1, v); chk("R5 flag cleared", v[0], 0);
    idle(); chk("R5 pending released", irq_o, 1);
    rd(2'd1, v); chk("R5 flag set again", v[0], 1);
    wr(2'd2, 16'h0001); idle();
    chk("R5 nothing left pending", irq_o, 0);

    // R6 write equal to count
    wr(2'd0, 16'h0013); ev(); ev();
    wr(2'd0, 16'h0012); chk("R6 equal write fires", irq_o, 1);
    wr(2'd2, 16'h0001);

    // R8 write below count
    wr(2'd0, 16'h0013); ev(); ev();
    wr(2'd0, 16'h0011); chk("R8 no irq on lower write", irq_o, 0);
    rd(2'd0, v); chk("R8 count zeroed", v[9:8], 0);

    // R7 event racing a period write
    drive(1, 1, 2'd0, 16'h0013, 2'b00);
    chk("R7 counted against new period", irq_o, 0);
    rd(2'd0, v); chk("R7 count incremented", v[9:8], 1);
    drive(1, 1, 2'd0, 16'h0012, 2'b00);
    chk("R7 match with new period", irq_o, 1);
    wr(2'd2, 16'h0001);

    // R3 enable off
    wr(2'd0, 16'h0001); ev();
    chk("R3 no irq when disabled", irq_o, 0);
    ev(); rd(2'd0, v); chk("R3 count holds at period", v[9:8], 1);
    wr(2'd0, 16'h0011); chk("R3 enabling fires held match", irq_o, 1);
    wr(2'd2, 16'h0001);

    // R9 force
    wr(2'd0, 16'h0013); wr(2'd2, 16'h0002);
    chk("R9 force fires", irq_o, 1);
    wr(2'd2, 16'h0001); wr(2'd0, 16'h0003); wr(2'd2, 16'h0002);
    chk("R9 force gated by enable", irq_o, 0);

    // R10 start-of-conversion flags
    drive(0, 0, 2'd1, 16'h0, 2'b01);
    chk("R10 pulse passes", soc_o, 2'b01);
    rd(2'd1, v); chk("R10 flag set", v, 16'h0010);
    drive(0, 0, 2'd1, 16'h0, 2'b01);
    chk("R10 pulse continues with flag set", soc_o, 2'b01);
    wr(2'd2, 16'h0010); rd(2'd1, v); chk("R10 flag cleared", v, 16'h0);
    drive(0, 1, 2'd2, 16'h0010, 2'b01);
    rd(2'd1, v); chk("R10 set wins over clear", v, 16'h0010);

    // R11 action and spare address read zero
    rd(2'd2, v); chk("R11 action reads zero", v, 16'h0);
    rd(2'd3, v); chk("R11 spare reads zero", v, 16'h0);

    // random traffic against the model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]  a, s;
      logic        e, w;
      logic [15:0] d;
      a = 2'($urandom % 4);
      rd(a, v);
      chk("R2 random read", v, exp_rd(a));
      chk("R5 random irq", irq_o, m_irq);
      chk("R10 random soc", soc_o, m_soc);
      e = ($urandom % 3) == 0;
      w = ($urandom % 5) == 0;
      d = (a == 2'd0) ? (16'($urandom) & 16'h0013) : (16'($urandom) & 16'h0033);
      s = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      drive(e, w, a, d, s);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule